// File: doc/BRIEF.md
# Decoded Receive Output Interface

This block is the last stage of an 8b/10b receive path. It sits after the symbol decoder and runs on the recovered byte-rate clock. For each valid symbol it registers the decoded byte, a control-character flag and a code-violation flag onto the parallel receive pins. It also produces an active-low ready strobe, which tells the downstream logic that a character has arrived. The link fills idle time with the comma pad character, and no ready strobe is given for that character. The downstream logic therefore sees only payload characters.

A mode input selects unencoded bypass. In bypass the decoder is ignored and the raw 10-bit code group is spread across the same ten output pins. The control pin and the violation pin become the two extra code bits. No character counts as a pad in this mode. All outputs change together on the rising clock edge. They keep their value while no symbol is presented.

Top module: `drx_rx_out`

## Requirements
- R1: While reset is active and after it releases, until the first symbol arrives: `q_data` is 0, `q_ctrl` is 0, `q_viol` is 0 and `rdy_n` is 1.
- R2: In encoded mode (`mode_raw`=0), a symbol accepted with `sym_vld`=1 appears one clock later on the outputs, with `q_data`=`dec_byte` and `q_ctrl`=`dec_ctrl`. A control code drives 1 and a data character drives 0.
- R3: In encoded mode, `q_viol` is 1 one clock after a symbol accepted with `dec_viol`=1, and 0 after a symbol with `dec_viol`=0.
- R4: `rdy_n` is 0 for exactly the one clock period that follows each delivered character, and 1 in every other cycle.
- R5: In encoded mode the pad character is `dec_ctrl`=1, `dec_byte`=8'hBC (K28.5) and `dec_viol`=0. It produces no ready strobe, but its values are still loaded onto `q_data`, `q_ctrl` and `q_viol`.
- R6: Two symbols are not pads and get a ready strobe: the data byte 8'hBC with `dec_ctrl`=0, and K28.5 flagged with `dec_viol`=1.
- R7: In bypass mode (`mode_raw`=1), `raw_sym` holds the code group with bit a at index 9, then b, c, d, e, i, f, g, h, and bit j at index 0. One clock after acceptance the pins show `q_ctrl`=`raw_sym[9]` (a), `q_data[k]`=`raw_sym[8-k]` for k=0..7 (b through h), and `q_viol`=`raw_sym[0]` (j).
- R8: In bypass mode every accepted symbol gives a ready strobe, even when the decoder inputs show the pad character.
- R9: While `sym_vld`=0, `q_data`, `q_ctrl` and `q_viol` hold their values, whatever the data inputs do.
- R10: Symbols on back-to-back cycles each appear for exactly one cycle. `rdy_n` stays 0 through a run of consecutive non-pad characters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte-rate receive clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_raw | input | 1 | 0 = encoded output, 1 = unencoded bypass |
| sym_vld | input | 1 | A symbol is presented this cycle |
| dec_byte | input | 8 | Decoded character value |
| dec_ctrl | input | 1 | Decoded character is a control code |
| dec_viol | input | 1 | Decoder found a code-rule violation |
| raw_sym | input | 10 | Undecoded code group, bit a at index 9 |
| q_data | output | 8 | Registered character or raw bits b..h |
| q_ctrl | output | 1 | Control/data select, or raw bit a |
| q_viol | output | 1 | Violation flag, or raw bit j |
| rdy_n | output | 1 | Active-low one-cycle character-ready strobe |

## Verification
The hardest case to reach is a pad character that arrives right after a delivered character. The outputs must change while `rdy_n` goes high in that same cycle. Near-pad lookalikes must still get their strobe. The stimulus places a true K28.5 directly after a data character. It then sends the data byte 0xBC and a K28.5 with a violation flag, and later a run of back-to-back characters with a pad in the middle. Bypass mode is then driven with the pad on the decoder inputs, single-bit raw patterns and the raw K28.5 code group. This shows that the pad rule is off and maps each code bit to its own pin.

// File: rtl/drx_pkg.sv
package drx_pkg;
   typedef enum logic {
      DRX_ENCODED = 1'b0,
      DRX_RAW     = 1'b1
   } drx_mode_e;

   localparam int unsigned DRX_BYTE_W   = 8;
   localparam int unsigned DRX_SYM_W    = 10;
   localparam logic [7:0]  DRX_PAD_CODE = 8'hBC;
endpackage

// File: rtl/drx_pad_detect.sv
module drx_pad_detect #(
   parameter int unsigned DATA_W   = 8,
   parameter bit          SUPPRESS = 1'b1,
   parameter logic [DATA_W-1:0] PAD_CODE = '0
) (
   input  logic              enc_mode,
   input  logic [DATA_W-1:0] chr_byte,
   input  logic              chr_ctrl,
   input  logic              chr_viol,
   output logic              is_pad
);
   generate
      if (SUPPRESS) begin : g_sup
         logic code_hit;
         assign code_hit = (chr_byte == PAD_CODE);
         assign is_pad   = enc_mode & chr_ctrl & ~chr_viol & code_hit;
      end else begin : g_nosup
         logic unused_in;
         assign unused_in = enc_mode ^ chr_ctrl ^ chr_viol ^ (^chr_byte);
         assign is_pad    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/drx_raw_map.sv
module drx_raw_map #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned SYM_W  = 10
) (
   input  logic [SYM_W-1:0]  raw_sym,
   output logic [DATA_W-1:0] map_data,
   output logic              map_ctrl,
   output logic              map_viol
);
   localparam int unsigned TOP_IDX = SYM_W - 1;

   assign map_ctrl = raw_sym[TOP_IDX];
   assign map_viol = raw_sym[0];

   genvar gi;
   generate
      for (gi = 0; gi < DATA_W; gi++) begin : g_bit
         assign map_data[gi] = raw_sym[TOP_IDX - 1 - gi];
      end
   endgenerate
endmodule

// File: rtl/drx_out_reg.sv
module drx_out_reg #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              hush,
   input  logic [DATA_W-1:0] nxt_data,
   input  logic              nxt_ctrl,
   input  logic              nxt_viol,
   output logic [DATA_W-1:0] q_data,
   output logic              q_ctrl,
   output logic              q_viol,
   output logic              rdy_n
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_data <= '0;
         q_ctrl <= 1'b0;
         q_viol <= 1'b0;
      end else if (load) begin
         q_data <= nxt_data;
         q_ctrl <= nxt_ctrl;
         q_viol <= nxt_viol;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdy_n <= 1'b1;
      else        rdy_n <= ~(load & ~hush);
   end
endmodule

// File: rtl/drx_rx_out.sv
module drx_rx_out
   import drx_pkg::*;
#(
   parameter int unsigned DATA_W    = DRX_BYTE_W,
   parameter int unsigned SYM_W     = DRX_SYM_W,
   parameter logic [DATA_W-1:0] PAD_CODE = DRX_PAD_CODE,
   parameter bit          BYPASS_EN = 1'b1,
   parameter bit          PAD_HUSH  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_raw,
   input  logic              sym_vld,
   input  logic [DATA_W-1:0] dec_byte,
   input  logic              dec_ctrl,
   input  logic              dec_viol,
   input  logic [SYM_W-1:0]  raw_sym,
   output logic [DATA_W-1:0] q_data,
   output logic              q_ctrl,
   output logic              q_viol,
   output logic              rdy_n
);
   localparam int unsigned EXTRA_BITS = SYM_W - DATA_W;

   generate
      if (EXTRA_BITS != 2) begin : g_bad_width
         $error("drx_rx_out: SYM_W must equal DATA_W + 2");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("drx_rx_out: DATA_W must be positive");
      end
   endgenerate

   drx_mode_e            mode_e;
   logic                 use_raw;
   logic [DATA_W-1:0]    raw_data;
   logic                 raw_ctrl;
   logic                 raw_viol;
   logic [DATA_W-1:0]    sel_data;
   logic                 sel_ctrl;
   logic                 sel_viol;
   logic                 pad_hit;

   generate
      if (BYPASS_EN) begin : g_bypass
         assign mode_e = drx_mode_e'(mode_raw);
         drx_raw_map #(
            .DATA_W (DATA_W),
            .SYM_W  (SYM_W)
         ) map_i (
            .raw_sym  (raw_sym),
            .map_data (raw_data),
            .map_ctrl (raw_ctrl),
            .map_viol (raw_viol)
         );
      end else begin : g_nobypass
         logic unused_raw;
         assign unused_raw = mode_raw ^ (^raw_sym);
         assign mode_e     = DRX_ENCODED;
         assign raw_data   = '0;
         assign raw_ctrl   = 1'b0;
         assign raw_viol   = 1'b0;
      end
   endgenerate

   assign use_raw = (mode_e == DRX_RAW);

   always_comb begin
      if (use_raw) begin
         sel_data = raw_data;
         sel_ctrl = raw_ctrl;
         sel_viol = raw_viol;
      end else begin
         sel_data = dec_byte;
         sel_ctrl = dec_ctrl;
         sel_viol = dec_viol;
      end
   end

   drx_pad_detect #(
      .DATA_W   (DATA_W),
      .SUPPRESS (PAD_HUSH),
      .PAD_CODE (PAD_CODE)
   ) pad_i (
      .enc_mode (~use_raw),
      .chr_byte (dec_byte),
      .chr_ctrl (dec_ctrl),
      .chr_viol (dec_viol),
      .is_pad   (pad_hit)
   );

   drx_out_reg #(
      .DATA_W (DATA_W)
   ) oreg_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (sym_vld),
      .hush     (pad_hit),
      .nxt_data (sel_data),
      .nxt_ctrl (sel_ctrl),
      .nxt_viol (sel_viol),
      .q_data   (q_data),
      .q_ctrl   (q_ctrl),
      .q_viol   (q_viol),
      .rdy_n    (rdy_n)
   );
endmodule

// File: rtl/drx_rx_out_chk.sv
module drx_rx_out_chk #(
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned SYM_W     = 10,
   parameter logic [DATA_W-1:0] PAD_CODE = 8'hBC,
   parameter bit          BYPASS_EN = 1'b1,
   parameter bit          PAD_HUSH  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_raw,
   input logic              sym_vld,
   input logic [DATA_W-1:0] dec_byte,
   input logic              dec_ctrl,
   input logic              dec_viol,
   input logic [SYM_W-1:0]  raw_sym,
   input logic [DATA_W-1:0] q_data,
   input logic              q_ctrl,
   input logic              q_viol,
   input logic              rdy_n
);
   logic in_raw;
   logic pad_in;
   assign in_raw = BYPASS_EN & mode_raw;
   assign pad_in = PAD_HUSH & ~in_raw & dec_ctrl & ~dec_viol & (dec_byte == PAD_CODE);

   a_r2_enc_load: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && !in_raw) |=> (q_data == $past(dec_byte) && q_ctrl == $past(dec_ctrl)));

   a_r3_viol_follow: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && !in_raw) |=> (q_viol == $past(dec_viol)));

   a_r4_rdy_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && !pad_in) |=> !rdy_n);

   a_r4_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_vld |=> rdy_n);

   a_r5_pad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && pad_in) |=> rdy_n);

   a_r7_raw_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && in_raw) |=> (q_ctrl == $past(raw_sym[SYM_W-1]) && q_viol == $past(raw_sym[0])));

   a_r7_raw_first: assert property (@(posedge clk) disable iff (!rst_n)
      (sym_vld && in_raw) |=> (q_data[0] == $past(raw_sym[SYM_W-2])));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !sym_vld |=> ($stable(q_data) && $stable(q_ctrl) && $stable(q_viol)));
endmodule

bind drx_rx_out drx_rx_out_chk #(
   .DATA_W    (DATA_W),
   .SYM_W     (SYM_W),
   .PAD_CODE  (PAD_CODE),
   .BYPASS_EN (BYPASS_EN),
   .PAD_HUSH  (PAD_HUSH)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .mode_raw (mode_raw),
   .sym_vld  (sym_vld),
   .dec_byte (dec_byte),
   .dec_ctrl (dec_ctrl),
   .dec_viol (dec_viol),
   .raw_sym  (raw_sym),
   .q_data   (q_data),
   .q_ctrl   (q_ctrl),
   .q_viol   (q_viol),
   .rdy_n    (rdy_n)
);

// File: tb/drx_rx_out_tb.sv
module drx_rx_out_tb_top;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_raw = 1'b0;
   logic       sym_vld = 1'b0;
   logic [7:0] dec_byte = '0;
   logic       dec_ctrl = 1'b0;
   logic       dec_viol = 1'b0;
   logic [9:0] raw_sym = '0;
   logic [7:0] q_data;
   logic       q_ctrl;
   logic       q_viol;
   logic       rdy_n;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [7:0] data;
      logic       ctrl;
      logic       viol;
      logic       rdy;
      string      tag;
   } exp_t;

   exp_t exp_q[$];
   logic [7:0] m_data = '0;
   logic       m_ctrl = 1'b0;
   logic       m_viol = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   drx_rx_out dut_i (
      .clk(clk), .rst_n(rst_n), .mode_raw(mode_raw), .sym_vld(sym_vld),
      .dec_byte(dec_byte), .dec_ctrl(dec_ctrl), .dec_viol(dec_viol),
      .raw_sym(raw_sym), .q_data(q_data), .q_ctrl(q_ctrl),
      .q_viol(q_viol), .rdy_n(rdy_n)
   );

   task automatic check1(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic send(input logic raw, input logic [7:0] b, input logic c,
                       input logic v, input logic [9:0] r, input string tag);
      exp_t e;
      bit pad;
      @(negedge clk);
      mode_raw = raw; sym_vld = 1'b1;
      dec_byte = b; dec_ctrl = c; dec_viol = v; raw_sym = r;
      if (raw) begin
         m_ctrl = r[9];
         for (int k = 0; k < 8; k++) m_data[k] = r[8-k];
         m_viol = r[0];
         pad = 1'b0;
      end else begin
         m_data = b; m_ctrl = c; m_viol = v;
         pad = (c == 1'b1) && (b == 8'hBC) && (v == 1'b0);
      end
      e.data = m_data; e.ctrl = m_ctrl; e.viol = m_viol;
      e.rdy = pad; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n, input string tag);
      exp_t e;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         sym_vld = 1'b0;
         dec_byte = 8'(i * 37 + 5); dec_ctrl = i[0]; dec_viol = ~i[0];
         raw_sym = 10'(i * 91 + 3);
         e.data = m_data; e.ctrl = m_ctrl; e.viol = m_viol;
         e.rdy = 1'b1; e.tag = tag;
         exp_q.push_back(e);
      end
   endtask

   // monitor: compares each expected item one cycle after it was driven
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            check1(e.tag, "q_data", q_data, e.data);
            check1(e.tag, "q_ctrl", {7'b0, q_ctrl}, {7'b0, e.ctrl});
            check1(e.tag, "q_viol", {7'b0, q_viol}, {7'b0, e.viol});
            check1(e.tag, "rdy_n", {7'b0, rdy_n}, {7'b0, e.rdy});
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state, during and just after reset
      repeat (3) @(negedge clk);
      check1("R1", "q_data", q_data, 8'h00);
      check1("R1", "rdy_n", {7'b0, rdy_n}, 8'h01);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check1("R1", "q_ctrl", {7'b0, q_ctrl}, 8'h00);
      check1("R1", "q_viol", {7'b0, q_viol}, 8'h00);
      check1("R1", "rdy_n", {7'b0, rdy_n}, 8'h01);

      // R2 / R3: encoded data and control characters
      send(1'b0, 8'hA5, 1'b0, 1'b0, 10'h155, "R2");
      idle(1, "R4");
      send(1'b0, 8'h3C, 1'b1, 1'b0, 10'h0F0, "R2");
      idle(1, "R4");
      send(1'b0, 8'h00, 1'b0, 1'b1, 10'h3FF, "R3");
      send(1'b0, 8'hFF, 1'b0, 1'b0, 10'h000, "R3");
      // R5: pad directly after a delivered character
      send(1'b0, 8'hBC, 1'b1, 1'b0, 10'h0FA, "R5");
      idle(2, "R9");
      // R6: lookalikes that still get a strobe
      send(1'b0, 8'hBC, 1'b0, 1'b0, 10'h0FA, "R6");
      send(1'b0, 8'hBC, 1'b1, 1'b1, 10'h0FA, "R6");
      idle(3, "R9");
      // R10: back-to-back run with a pad inside
      send(1'b0, 8'h11, 1'b0, 1'b0, 10'h001, "R10");
      send(1'b0, 8'h22, 1'b0, 1'b0, 10'h002, "R10");
      send(1'b0, 8'hBC, 1'b1, 1'b0, 10'h003, "R5");
      send(1'b0, 8'h44, 1'b1, 1'b0, 10'h004, "R10");
      send(1'b0, 8'h55, 1'b0, 1'b0, 10'h005, "R10");
      idle(1, "R4");
      // R7: bypass mapping, single bits then mixed patterns
      send(1'b1, 8'h00, 1'b0, 1'b0, 10'b1000000000, "R7");
      send(1'b1, 8'h00, 1'b0, 1'b0, 10'b0100000000, "R7");
      send(1'b1, 8'h00, 1'b0, 1'b0, 10'b0000000010, "R7");
      send(1'b1, 8'h00, 1'b0, 1'b0, 10'b0000000001, "R7");
      send(1'b1, 8'hFF, 1'b1, 1'b1, 10'h2AA, "R7");
      send(1'b1, 8'h00, 1'b0, 1'b0, 10'h0C3, "R7");
      // R8: pad on decoder inputs and raw K28.5 code group in bypass
      send(1'b1, 8'hBC, 1'b1, 1'b0, 10'b0011111010, "R8");
      send(1'b1, 8'hBC, 1'b1, 1'b0, 10'b1100000101, "R8");
      idle(2, "R9");
      // back to encoded: pad suppressed again
      send(1'b0, 8'hBC, 1'b1, 1'b0, 10'h3FF, "R5");
      send(1'b0, 8'h5A, 1'b0, 1'b0, 10'h3FF, "R2");
      idle(2, "R4");

      while (exp_q.size() > 0) @(posedge clk);
      repeat (2) @(posedge clk);
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule